// File: doc/BRIEF.md
# Push-Button Debouncer with Press and Release Strobes

This block cleans up the contact bounce of a mechanical push button. The raw button level enters a fast clock domain through a flop synchroniser. It is then sampled at a slow rate set by an internal clock-enable divider. With a 50 MHz clock and the default ratio, the sampling rate is 50 Hz, so one sample period is 20 ms. The debounced level follows the button only when two consecutive slow samples agree on the new value. Bounce and short glitches therefore never reach the output.

Each change of the debounced level also raises one of two separate strobes. A press (low to high) raises `press_o`, and a release (high to low) raises `release_o`. Each strobe starts in the same cycle as the level change and lasts exactly one slow sample period. It then falls on the next sample strobe. Downstream logic that runs at the slow rate sees each strobe in exactly one of its sample slots. The two strobes are never high together. Everything runs on one clock. The slow rate is a one-cycle enable, and the divider ratio is a parameter, so a simulation can use a short period.

Top module: `btn_debounce_pulse`

## Requirements
- R1: Once `btn_i` has been held at a new level, `level_o` takes that level within 2*DIV_RATIO+4 clock cycles. This covers two synchroniser flops, up to one partial sample period and one full sample period.
- R2: `level_o` changes only in the cycle that follows a sample strobe, and only when the two most recent samples of the synchronised input both equal the new level. A pulse of either polarity on `btn_i` that lasts fewer than DIV_RATIO cycles leaves `level_o`, `press_o` and `release_o` unchanged.
- R3: `press_o` rises in the same cycle that `level_o` rises from 0 to 1, and at no other time.
- R4: `release_o` rises in the same cycle that `level_o` falls from 1 to 0, and at no other time.
- R5: Each high period of `press_o` or `release_o` lasts exactly DIV_RATIO clock cycles, which is one slow sample period.
- R6: `press_o` and `release_o` are never both 1 in the same cycle.
- R7: While `rst_ni` is 0, `level_o`, `press_o` and `release_o` are 0. After reset, with the button released, they stay 0.
- R8: The sample strobe is one clock cycle wide and repeats every DIV_RATIO clock cycles, counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Raw button level, asynchronous, 1 = pressed |
| level_o | output | 1 | Debounced button level, 1 = pressed |
| press_o | output | 1 | High for one sample period after a debounced press |
| release_o | output | 1 | High for one sample period after a debounced release |

## Verification
The assertions check four things on every cycle: the spacing of the sample strobe, that `level_o` only moves after a strobe, the exact DIV_RATIO width of each strobe, and that the strobes follow the level edges and never overlap. What happens in response to real input patterns is shown only by the bench's scenarios. These cover bouncy presses and releases, the latency bound from a settled input to the new level, and short glitches of both polarities being rejected. The reset values are also checked only by the bench.

// File: rtl/btn_deb_pkg.sv
package btn_deb_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } lvl_chg_t;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= sh_q[g-1];
      end
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/sample_tick_gen.sv
module sample_tick_gen
  import btn_deb_pkg::*;
#(
  parameter int DIV_RATIO = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CNT_W = cnt_width(DIV_RATIO);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = wrap;

endmodule

// File: rtl/debounce_filter.sv
module debounce_filter
  import btn_deb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     sample_i,
  output logic     level_o,
  output lvl_chg_t chg_o
);

  logic prev_q;
  logic lvl_q;
  logic agree;

  // two consecutive samples agree
  assign agree = (sample_i == prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (tick_i) begin
      prev_q <= sample_i;
      if (agree) lvl_q <= sample_i;
    end
  end

  always_comb begin
    chg_o.rise = tick_i & agree &  sample_i & ~lvl_q;
    chg_o.fall = tick_i & agree & ~sample_i &  lvl_q;
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/edge_pulse_hold.sv
module edge_pulse_hold
  import btn_deb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  lvl_chg_t chg_i,
  output logic     press_o,
  output logic     release_o
);

  logic press_q;
  logic rel_q;

  // set on a sample strobe, held until the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      press_q <= 1'b0;
      rel_q   <= 1'b0;
    end else if (tick_i) begin
      press_q <= chg_i.rise;
      rel_q   <= chg_i.fall;
    end
  end

  assign press_o   = press_q;
  assign release_o = rel_q;

endmodule

// File: rtl/btn_debounce_pulse.sv
module btn_debounce_pulse
  import btn_deb_pkg::*;
#(
  parameter int DIV_RATIO   = 1_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic level_o,
  output logic press_o,
  output logic release_o
);

  logic     btn_s;
  logic     smp_tick;
  lvl_chg_t chg;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (btn_i),
    .q_o    (btn_s)
  );

  sample_tick_gen #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (smp_tick)
  );

  debounce_filter u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (smp_tick),
    .sample_i (btn_s),
    .level_o  (level_o),
    .chg_o    (chg)
  );

  edge_pulse_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (smp_tick),
    .chg_i     (chg),
    .press_o   (press_o),
    .release_o (release_o)
  );

endmodule

// File: rtl/btn_debounce_pulse_chk.sv
module btn_debounce_pulse_chk #(
  parameter int DIV_RATIO = 1_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick,
  input logic level_o,
  input logic press_o,
  input logic release_o
);

  localparam int W = $clog2(DIV_RATIO + 2);

  logic [W-1:0] gap_q;
  logic [W-1:0] plen_q;
  logic [W-1:0] rlen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      plen_q <= '0;
      rlen_q <= '0;
    end else begin
      gap_q  <= tick      ? '0 : gap_q + 1'b1;
      plen_q <= press_o   ? plen_q + 1'b1 : '0;
      rlen_q <= release_o ? rlen_q + 1'b1 : '0;
    end
  end

  // R8
  tick_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> gap_q == W'(DIV_RATIO - 1));

  // R2
  level_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick) |-> $stable(level_o));

  // R3
  press_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(press_o) |-> $rose(level_o));

  // R3
  rise_gives_press_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> press_o);

  // R4
  release_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(release_o) |-> $fell(level_o));

  // R4
  fall_gives_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_o) |-> release_o);

  // R5
  press_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(press_o) |-> plen_q == W'(DIV_RATIO));

  // R5
  release_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(release_o) |-> rlen_q == W'(DIV_RATIO));

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(press_o && release_o));

endmodule

bind btn_debounce_pulse btn_debounce_pulse_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick      (smp_tick),
  .level_o   (level_o),
  .press_o   (press_o),
  .release_o (release_o)
);

// File: tb/btn_debounce_pulse_tb.sv
module btn_debounce_pulse_tb;

  localparam int DIV   = 8;
  localparam int BOUND = 2 * DIV + 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic btn_i = 1'b0;
  logic level_o, press_o, release_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int press_rises = 0, rel_rises = 0, overlap = 0, bad_edge = 0;
  int press_len = 0, rel_len = 0, last_press_len = 0, last_rel_len = 0;
  logic prev_lvl = 1'b0, prev_press = 1'b0, prev_rel = 1'b0;

  always #10 clk_i = ~clk_i;

  btn_debounce_pulse #(.DIV_RATIO(DIV)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .btn_i     (btn_i),
    .level_o   (level_o),
    .press_o   (press_o),
    .release_o (release_o)
  );

  // port monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (press_o && release_o) overlap++;
      if (press_o && !prev_press) begin
        press_rises++;
        if (!(level_o && !prev_lvl)) bad_edge++;
      end
      if (release_o && !prev_rel) begin
        rel_rises++;
        if (!(!level_o && prev_lvl)) bad_edge++;
      end
      if (press_o) press_len++;
      else if (prev_press) begin last_press_len = press_len; press_len = 0; end
      if (release_o) rel_len++;
      else if (prev_rel) begin last_rel_len = rel_len; rel_len = 0; end
    end
    prev_lvl   = level_o;
    prev_press = press_o;
    prev_rel   = release_o;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bounce(input int toggles);
    for (int i = 0; i < toggles; i++) begin
      btn_i = ~btn_i;
      wait_cyc(2);
    end
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    wait_cyc(3);
    check("R7", "level in reset", int'(level_o), 0);
    check("R7", "press in reset", int'(press_o), 0);
    check("R7", "release in reset", int'(release_o), 0);
    rst_ni = 1'b1;
    wait_cyc(4 * DIV);
    check("R7", "outputs idle after reset",
          int'(level_o) + int'(press_o) + int'(release_o), 0);
  endtask

  task automatic test_glitch_high();
    int p0 = press_rises;
    for (int i = 0; i < 5; i++) begin
      btn_i = 1'b1; wait_cyc(DIV / 2);
      btn_i = 1'b0; wait_cyc(3 * DIV);
    end
    @(posedge clk_i);
    check("R2", "level after short high glitches", int'(level_o), 0);
    check("R2", "press pulses from glitches", press_rises - p0, 0);
  endtask

  task automatic test_press();
    int p0 = press_rises, r0 = rel_rises, lat = 0;
    bounce(7);              // ends high
    btn_i = 1'b1;
    while (!level_o && lat < BOUND + 2) begin @(negedge clk_i); lat++; end
    check("R1", "press latency within bound", int'(lat <= BOUND), 1);
    check("R3", "press_o high with level rise", int'(press_o), 1);
    wait_cyc(2 * DIV);
    @(posedge clk_i);
    check("R3", "press pulse count", press_rises - p0, 1);
    check("R5", "press pulse width", last_press_len, DIV);
    check("R4", "no release on press", rel_rises - r0, 0);
  endtask

  task automatic test_glitch_low();
    int r0 = rel_rises;
    for (int i = 0; i < 4; i++) begin
      btn_i = 1'b0; wait_cyc(DIV - 2);
      btn_i = 1'b1; wait_cyc(3 * DIV);
    end
    @(posedge clk_i);
    check("R2", "level after short low glitches", int'(level_o), 1);
    check("R2", "release pulses from glitches", rel_rises - r0, 0);
  endtask

  task automatic test_release();
    int p0 = press_rises, r0 = rel_rises, lat = 0;
    bounce(7);              // ends low
    btn_i = 1'b0;
    while (level_o && lat < BOUND + 2) begin @(negedge clk_i); lat++; end
    check("R1", "release latency within bound", int'(lat <= BOUND), 1);
    check("R4", "release_o high with level fall", int'(release_o), 1);
    wait_cyc(2 * DIV);
    @(posedge clk_i);
    check("R4", "release pulse count", rel_rises - r0, 1);
    check("R5", "release pulse width", last_rel_len, DIV);
    check("R3", "no press on release", press_rises - p0, 0);
  endtask

  task automatic test_quick_tap();
    int p0 = press_rises, r0 = rel_rises;
    btn_i = 1'b1; wait_cyc(3 * DIV);
    btn_i = 1'b0; wait_cyc(5 * DIV);
    @(posedge clk_i);
    check("R3", "tap press count", press_rises - p0, 1);
    check("R4", "tap release count", rel_rises - r0, 1);
    check("R6", "no overlap on tap", overlap, 0);
    // R8: strobe spacing seen through pulse width
    check("R8", "tap press width", last_press_len, DIV);
  endtask

  initial begin
    test_reset();
    test_glitch_high();
    test_press();
    test_glitch_low();
    test_release();
    test_quick_tap();
    check("R6", "total overlap cycles", overlap, 0);
    check("R3", "pulse edges off level edges", bad_edge, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule